// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects a parameterised number of external interrupt lines (a multiple of eight) and turns them into one request output per processor context. Software programs each line through a 32-bit register bus: it picks whether the line is active high or active low, whether it is level or edge sensitive, and whether an edge-sensitive line should latch on both transitions. It also enables and disables lines without read-modify-write sequences and decides which context receives each line.

Edge-sensitive lines hold their pending state in a latch. A single software-edge register can raise that latch, which serves as an inter-processor doorbell, or drop it, which acknowledges a serviced edge. For every context the block presents a request flag and the number of the lowest-numbered line that is routed to it, pending and enabled. A read-only word reports the line and context counts. The external lines are assumed synchronous to `clk`.

Top module: `shirq_ctrl`

## Requirements
- R1: After reset every line is active high, level sensitive, single-edge, disabled and routed to context 0; all `ctx_irq` bits are low, and the polarity (byte 0x100), trigger (0x180), dual-edge (0x200) and enable (0x280) word arrays read 0, where word k of an array covers lines 32k to 32k+31 at base+4k.
- R2: The word at byte address 0x000 is read-only and reads (NUM_LINES/8-1) in bits [23:16] and (NUM_CTX-1) in bits [7:0], all other bits zero.
- R3: A level-sensitive line is pending while its input differs from its polarity bit (polarity bit 1 means active low); the pending array at 0x400 shows the live state.
- R4: An edge-sensitive line (trigger bit 1) with dual-edge off latches pending on a rising input when its polarity bit is 0, on a falling input when it is 1, and the latch stays set after the input returns.
- R5: An edge-sensitive line with its dual-edge bit set latches on both rising and falling inputs, whatever its polarity bit holds.
- R6: Writing to 0x300 enables every line whose data bit is 1; writing to 0x380 disables every line whose data bit is 1; 0 bits leave lines unchanged, and a disabled pending line never raises a context output.
- R7: A write to 0x004 with bit 31 = 1 sets the edge latch of the line in bits [7:0], with bit 31 = 0 clears it; a line number not below NUM_LINES is ignored, and a hardware edge detected in the same cycle as a clear leaves the latch set.
- R8: Line i is routed to the context held in bits [CTX_W-1:0] of the map word at 0x800+4*i (readable); rewriting it moves the line, and a value not below NUM_CTX is ignored.
- R9: `ctx_irq[c]` is high exactly when some line routed to context c is pending and enabled, and that context's field of `ctx_idx` carries the lowest such line number; both are registered, one clock edge after their inputs.
- R10: `rd_data` loads on the clock edge where `rd_en` is high and holds otherwise; addresses that decode to nothing, and array words beyond the last line, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid after the edge that sampled `rd_en` |
| irq_in | input | NUM_LINES | External interrupt lines |
| ctx_irq | output | NUM_CTX | Per-context request |
| ctx_idx | output | NUM_CTX*IDX_W | Per-context lowest active line number |

## Verification
A level input change reaches `ctx_irq` on the first clock edge, while an input edge needs two: one to set the latch and one to register the context output. A register write takes effect on its own edge and is visible at the context outputs one edge later, and read data appears after the edge that sampled `rd_en`. The bench drives everything on the falling edge and waits exactly those numbers of falling edges before it samples, so every check lands on the first cycle the result is due and a result that arrives a cycle late or early is caught.

// File: rtl/shirq_pkg.sv
package shirq_pkg;

  localparam int          BUS_W     = 32;
  localparam int          ADDR_W    = 12;
  localparam int          EDGE_SET  = 31;
  localparam int          EDGE_NUMW = 8;

  localparam logic [11:0] CFG_ADDR   = 12'h000;
  localparam logic [11:0] EDGE_ADDR  = 12'h004;
  localparam logic [11:0] SMASK_ADDR = 12'h300;
  localparam logic [11:0] RMASK_ADDR = 12'h380;

  typedef enum logic [3:0] {
    ACC_NONE,
    ACC_CFG,
    ACC_EDGE,
    ACC_POL,
    ACC_TRIG,
    ACC_DUAL,
    ACC_MASK,
    ACC_SMASK,
    ACC_RMASK,
    ACC_PEND,
    ACC_MAP
  } acc_e;

  // Region select uses addr[11:7]; map words fill the upper half.
  function automatic acc_e decode_addr(input logic [ADDR_W-1:0] a);
    acc_e r;
    r = ACC_NONE;
    if (a[11]) begin
      r = ACC_MAP;
    end else begin
      case (a[10:7])
        4'd0: begin
          if (a[6:0] == 7'h00)      r = ACC_CFG;
          else if (a[6:0] == 7'h04) r = ACC_EDGE;
        end
        4'd2:    r = ACC_POL;
        4'd3:    r = ACC_TRIG;
        4'd4:    r = ACC_DUAL;
        4'd5:    r = ACC_MASK;
        4'd6:    r = ACC_SMASK;
        4'd7:    r = ACC_RMASK;
        4'd8:    r = ACC_PEND;
        default: r = ACC_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/shirq_regs.sv
module shirq_regs
  import shirq_pkg::*;
#(
  parameter int N  = 40,
  parameter int C  = 3,
  parameter int CW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wr_data,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      trig_o,
  output logic [N-1:0]      dual_o,
  output logic [N-1:0]      mask_o,
  output logic [N*CW-1:0]   map_o,
  output logic [N-1:0]      sw_set_o,
  output logic [N-1:0]      sw_clr_o
);

  acc_e                 wacc;
  logic [4:0]           widx;
  logic [8:0]           wline;
  logic [EDGE_NUMW-1:0] eline;
  logic                 ctx_ok;

  logic [N-1:0]    pol_q, pol_d;
  logic [N-1:0]    trig_q, trig_d;
  logic [N-1:0]    dual_q, dual_d;
  logic [N-1:0]    mask_q, mask_d;
  logic [N*CW-1:0] map_q, map_d;
  logic            cfg_we;

  assign wacc   = wr_en ? decode_addr(addr) : ACC_NONE;
  assign widx   = addr[6:2];
  assign wline  = addr[10:2];
  assign eline  = wr_data[EDGE_NUMW-1:0];
  assign ctx_ok = ({1'b0, wr_data[CW-1:0]} < (CW+1)'(C));
  assign cfg_we = (wacc == ACC_POL) || (wacc == ACC_TRIG) || (wacc == ACC_DUAL) ||
                  (wacc == ACC_SMASK) || (wacc == ACC_RMASK) || (wacc == ACC_MAP);

  always_comb begin
    pol_d  = pol_q;
    trig_d = trig_q;
    dual_d = dual_q;
    mask_d = mask_q;
    map_d  = map_q;
    for (int i = 0; i < N; i++) begin
      if (widx == 5'(i / 32)) begin
        if (wacc == ACC_POL)  pol_d[i]  = wr_data[i % 32];
        if (wacc == ACC_TRIG) trig_d[i] = wr_data[i % 32];
        if (wacc == ACC_DUAL) dual_d[i] = wr_data[i % 32];
        if ((wacc == ACC_SMASK) && wr_data[i % 32]) mask_d[i] = 1'b1;
        if ((wacc == ACC_RMASK) && wr_data[i % 32]) mask_d[i] = 1'b0;
      end
      if ((wacc == ACC_MAP) && (wline == 9'(i)) && ctx_ok)
        map_d[i*CW +: CW] = wr_data[CW-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      sw_set_o[i] = (wacc == ACC_EDGE) &&  wr_data[EDGE_SET] && (eline == EDGE_NUMW'(i));
      sw_clr_o[i] = (wacc == ACC_EDGE) && !wr_data[EDGE_SET] && (eline == EDGE_NUMW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      trig_q <= '0;
      dual_q <= '0;
      mask_q <= '0;
      map_q  <= '0;
    end else if (cfg_we) begin
      pol_q  <= pol_d;
      trig_q <= trig_d;
      dual_q <= dual_d;
      mask_q <= mask_d;
      map_q  <= map_d;
    end
  end

  assign pol_o  = pol_q;
  assign trig_o = trig_q;
  assign dual_o = dual_q;
  assign mask_o = mask_q;
  assign map_o  = map_q;

endmodule

// File: rtl/shirq_detect.sv
module shirq_detect #(
  parameter int N = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] dual,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] sw_clr,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] latch_o
);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic prev_q;
    logic latch_q, latch_d;
    logic rise, fall, hw_edge, active;

    always_comb begin
      active  = irq_in[i] ^ pol[i];
      rise    = irq_in[i] & ~prev_q;
      fall    = ~irq_in[i] & prev_q;
      if (dual[i])     hw_edge = trig[i] & (rise | fall);
      else if (pol[i]) hw_edge = trig[i] & fall;
      else             hw_edge = trig[i] & rise;
      // a detected edge outranks a software clear in the same cycle
      latch_d = hw_edge | sw_set[i] | (latch_q & ~sw_clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        prev_q  <= irq_in[i];
        latch_q <= latch_d;
      end
    end

    assign pend_o[i]  = trig[i] ? latch_q : active;
    assign latch_o[i] = latch_q;
  end

endmodule

// File: rtl/shirq_route.sv
module shirq_route #(
  parameter int N  = 40,
  parameter int C  = 3,
  parameter int CW = 2,
  parameter int IW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    pend,
  input  logic [N-1:0]    mask,
  input  logic [N*CW-1:0] map,
  output logic [C-1:0]    ctx_irq_o,
  output logic [C*IW-1:0] ctx_idx_o
);

  for (genvar c = 0; c < C; c++) begin : g_ctx
    logic [N-1:0]  sel;
    logic          hit_d, hit_q;
    logic [IW-1:0] idx_d, idx_q;

    always_comb begin
      for (int i = 0; i < N; i++)
        sel[i] = pend[i] & mask[i] & (map[i*CW +: CW] == CW'(c));
      hit_d = |sel;
      idx_d = '0;
      for (int i = N - 1; i >= 0; i--)
        if (sel[i]) idx_d = IW'(i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q <= 1'b0;
        idx_q <= '0;
      end else begin
        hit_q <= hit_d;
        idx_q <= idx_d;
      end
    end

    assign ctx_irq_o[c]            = hit_q;
    assign ctx_idx_o[c*IW +: IW]   = idx_q;
  end

endmodule

// File: rtl/shirq_ctrl.sv
module shirq_ctrl
  import shirq_pkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter int NUM_CTX   = 3,
  localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [11:0]              addr,
  input  logic [31:0]              wr_data,
  output logic [31:0]              rd_data,
  input  logic [NUM_LINES-1:0]     irq_in,
  output logic [NUM_CTX-1:0]       ctx_irq,
  output logic [NUM_CTX*IDX_W-1:0] ctx_idx
);

  localparam int NW = (NUM_LINES + 31) / 32;
  localparam logic [31:0] CFG_WORD = {8'h00, 8'(NUM_LINES / 8 - 1), 8'h00, 8'(NUM_CTX - 1)};

  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic [NUM_LINES-1:0]       pol, trig, dual, mask, pend, latch, sw_set, sw_clr;
  logic [NUM_LINES*CTX_W-1:0] map;

  shirq_regs #(.N(NUM_LINES), .C(NUM_CTX), .CW(CTX_W)) u_regs (
    .clk      (clk),
    .rst_n    (srst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .pol_o    (pol),
    .trig_o   (trig),
    .dual_o   (dual),
    .mask_o   (mask),
    .map_o    (map),
    .sw_set_o (sw_set),
    .sw_clr_o (sw_clr)
  );

  shirq_detect #(.N(NUM_LINES)) u_detect (
    .clk     (clk),
    .rst_n   (srst_n),
    .irq_in  (irq_in),
    .pol     (pol),
    .trig    (trig),
    .dual    (dual),
    .sw_set  (sw_set),
    .sw_clr  (sw_clr),
    .pend_o  (pend),
    .latch_o (latch)
  );

  shirq_route #(.N(NUM_LINES), .C(NUM_CTX), .CW(CTX_W), .IW(IDX_W)) u_route (
    .clk       (clk),
    .rst_n     (srst_n),
    .pend      (pend),
    .mask      (mask),
    .map       (map),
    .ctx_irq_o (ctx_irq),
    .ctx_idx_o (ctx_idx)
  );

  // read path: pad each array to whole words, then pick one
  logic [NW*32-1:0] pol_w, trig_w, dual_w, mask_w, pend_w;
  logic [4:0]       ridx;
  logic [8:0]       rline;
  logic [31:0]      rd_d, rd_q;
  logic             word_ok;

  assign ridx    = addr[6:2];
  assign rline   = addr[10:2];
  assign word_ok = (int'(ridx) < NW);

  always_comb begin
    pol_w  = '0;
    trig_w = '0;
    dual_w = '0;
    mask_w = '0;
    pend_w = '0;
    pol_w[NUM_LINES-1:0]  = pol;
    trig_w[NUM_LINES-1:0] = trig;
    dual_w[NUM_LINES-1:0] = dual;
    mask_w[NUM_LINES-1:0] = mask;
    pend_w[NUM_LINES-1:0] = pend;
    rd_d = '0;
    case (decode_addr(addr))
      ACC_CFG:  rd_d = CFG_WORD;
      ACC_POL:  if (word_ok) rd_d = pol_w[32*int'(ridx) +: 32];
      ACC_TRIG: if (word_ok) rd_d = trig_w[32*int'(ridx) +: 32];
      ACC_DUAL: if (word_ok) rd_d = dual_w[32*int'(ridx) +: 32];
      ACC_MASK: if (word_ok) rd_d = mask_w[32*int'(ridx) +: 32];
      ACC_PEND: if (word_ok) rd_d = pend_w[32*int'(ridx) +: 32];
      ACC_MAP:  if (int'(rline) < NUM_LINES) rd_d = 32'(map[CTX_W*int'(rline) +: CTX_W]);
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/shirq_ctrl_chk.sv
module shirq_ctrl_chk
  import shirq_pkg::*;
#(
  parameter int N  = 40,
  parameter int C  = 3,
  parameter int CW = 2,
  parameter int IW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [11:0]     addr,
  input logic [31:0]     wr_data,
  input logic [31:0]     rd_data,
  input logic [N-1:0]    mask,
  input logic [N*CW-1:0] map,
  input logic [N-1:0]    latch,
  input logic [N-1:0]    sw_clr,
  input logic [C-1:0]    ctx_irq,
  input logic [C*IW-1:0] ctx_idx
);

  // R6
  smask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SMASK_ADDR && wr_data[0]) |=> mask[0]);

  // R6
  rmask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RMASK_ADDR && wr_data[0]) |=> !mask[0]);

  // R7
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == EDGE_ADDR && wr_data[EDGE_SET] && wr_data[7:0] == 8'd0) |=> latch[0]);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  for (genvar i = 0; i < N; i++) begin : g_line
    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch[i] && !sw_clr[i]) |=> latch[i]);

    // R8
    map_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, map[i*CW +: CW]} < (CW+1)'(C)));
  end

  for (genvar c = 0; c < C; c++) begin : g_ctx
    // R9
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_irq[c] |-> (int'(ctx_idx[c*IW +: IW]) < N));
  end

endmodule

bind shirq_ctrl shirq_ctrl_chk #(
  .N(NUM_LINES), .C(NUM_CTX), .CW(CTX_W), .IW(IDX_W)
) u_chk (
  .clk     (clk),
  .rst_n   (srst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .mask    (mask),
  .map     (map),
  .latch   (latch),
  .sw_clr  (sw_clr),
  .ctx_irq (ctx_irq),
  .ctx_idx (ctx_idx)
);

// File: tb/shirq_ctrl_test.sv
module shirq_ctrl_test;

  localparam int N  = 40;
  localparam int C  = 3;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [11:0]   addr;
  logic [31:0]   wr_data, rd_data;
  logic [N-1:0]  irq_in;
  logic [C-1:0]  ctx_irq;
  logic [C*IW-1:0] ctx_idx;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  shirq_ctrl #(.NUM_LINES(N), .NUM_CTX(C)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_in(irq_in),
    .ctx_irq(ctx_irq), .ctx_idx(ctx_idx)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] idx_of(input int c);
    return 32'(ctx_idx[c*IW +: IW]);
  endfunction

  // all tasks start and end on a falling edge
  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic disable_all();
    bus_write(12'h380, 32'hFFFF_FFFF);
    bus_write(12'h384, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "ctx_irq after reset", 32'(ctx_irq), 32'h0);
    bus_read(12'h100, d); chk("R1", "polarity word0", d, 32'h0);
    bus_read(12'h184, d); chk("R1", "trigger word1", d, 32'h0);
    bus_read(12'h200, d); chk("R1", "dual word0", d, 32'h0);
    bus_read(12'h280, d); chk("R1", "enable word0", d, 32'h0);
    bus_read(12'h284, d); chk("R1", "enable word1", d, 32'h0);
    bus_read(12'h800 + 12'(4*17), d); chk("R1", "map line17", d, 32'h0);
  endtask

  task automatic t_config();
    logic [31:0] d;
    bus_read(12'h000, d); chk("R2", "config word", d, 32'h0004_0002);
  endtask

  task automatic t_level();
    logic [31:0] d;
    bus_write(12'h300, 32'h0000_0008);
    irq_in[3] = 1'b1; settle(1);
    chk("R3", "level high ctx0", 32'(ctx_irq), 32'h1);
    chk("R3", "level idx", idx_of(0), 32'd3);
    bus_read(12'h400, d); chk("R3", "pending word0", d, 32'h0000_0008);
    irq_in[3] = 1'b0; settle(1);
    chk("R3", "level drops", 32'(ctx_irq), 32'h0);
    bus_write(12'h100, 32'h0000_0008); settle(1);
    chk("R3", "active-low line with input low", 32'(ctx_irq), 32'h1);
    bus_write(12'h100, 32'h0); settle(1);
    chk("R3", "polarity restored", 32'(ctx_irq), 32'h0);
    disable_all();
  endtask

  task automatic t_edge();
    bus_write(12'h180, 32'h0000_0020);
    bus_write(12'h300, 32'h0000_0020);
    irq_in[5] = 1'b1; settle(2);
    chk("R4", "rising latches", 32'(ctx_irq), 32'h1);
    chk("R4", "edge idx", idx_of(0), 32'd5);
    irq_in[5] = 1'b0; settle(2);
    chk("R4", "latch held after input low", 32'(ctx_irq), 32'h1);
    bus_write(12'h004, 32'h0000_0005); settle(1);
    chk("R7", "clear acknowledges", 32'(ctx_irq), 32'h0);
    bus_write(12'h100, 32'h0000_0020);
    irq_in[5] = 1'b1; settle(2);
    chk("R4", "falling mode ignores rise", 32'(ctx_irq), 32'h0);
    irq_in[5] = 1'b0; settle(2);
    chk("R4", "falling mode latches fall", 32'(ctx_irq), 32'h1);
    bus_write(12'h004, 32'h0000_0005);
    bus_write(12'h100, 32'h0);
    bus_write(12'h180, 32'h0);
    disable_all();
  endtask

  task automatic t_dual();
    logic [31:0] d;
    bus_write(12'h184, 32'h2);
    bus_write(12'h204, 32'h2);
    bus_write(12'h104, 32'h2);
    bus_write(12'h800 + 12'(4*33), 32'h2);
    bus_write(12'h304, 32'h2);
    irq_in[33] = 1'b1; settle(2);
    chk("R5", "dual rise to ctx2", 32'(ctx_irq), 32'h4);
    chk("R5", "dual idx", idx_of(2), 32'd33);
    bus_read(12'h404, d); chk("R5", "pending word1", d, 32'h2);
    bus_write(12'h004, 32'h0000_0021); settle(1);
    chk("R5", "dual cleared", 32'(ctx_irq), 32'h0);
    irq_in[33] = 1'b0; settle(2);
    chk("R5", "dual fall latches", 32'(ctx_irq), 32'h4);
    bus_write(12'h004, 32'h0000_0021);
    bus_write(12'h184, 32'h0);
    bus_write(12'h204, 32'h0);
    bus_write(12'h104, 32'h0);
    bus_write(12'h800 + 12'(4*33), 32'h0);
    disable_all();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bus_write(12'h300, 32'h3);
    bus_read(12'h280, d); chk("R6", "set two lines", d, 32'h3);
    bus_write(12'h300, 32'h0);
    bus_read(12'h280, d); chk("R6", "zero set bits no effect", d, 32'h3);
    bus_write(12'h380, 32'h1);
    bus_read(12'h280, d); chk("R6", "clear one line", d, 32'h2);
    irq_in[0] = 1'b1; settle(1);
    chk("R6", "disabled line blocked", 32'(ctx_irq), 32'h0);
    irq_in[1] = 1'b1; settle(1);
    chk("R6", "enabled line passes", idx_of(0), 32'd1);
    irq_in[0] = 1'b0; irq_in[1] = 1'b0;
    disable_all();
  endtask

  task automatic t_wedge();
    logic [31:0] d;
    bus_write(12'h180, 32'h0000_0080);
    bus_write(12'h300, 32'h0000_0080);
    bus_write(12'h004, 32'h8000_0007); settle(1);
    chk("R7", "software set", 32'(ctx_irq), 32'h1);
    chk("R7", "software set idx", idx_of(0), 32'd7);
    bus_write(12'h004, 32'h8000_0030);
    bus_read(12'h404, d); chk("R7", "out-of-range line ignored", d, 32'h0);
    // rising input in the same cycle as a clear
    irq_in[7] = 1'b1;
    bus_write(12'h004, 32'h0000_0007); settle(1);
    chk("R7", "hardware edge beats clear", 32'(ctx_irq), 32'h1);
    bus_write(12'h004, 32'h0000_0007); settle(1);
    chk("R7", "clear after collision", 32'(ctx_irq), 32'h0);
    irq_in[7] = 1'b0;
    bus_write(12'h180, 32'h0);
    disable_all();
  endtask

  task automatic t_route();
    logic [31:0] d;
    bus_write(12'h300, 32'h0000_0400);
    irq_in[10] = 1'b1; settle(1);
    chk("R8", "default context 0", 32'(ctx_irq), 32'h1);
    bus_write(12'h828, 32'h1); settle(1);
    chk("R8", "moved to ctx1", 32'(ctx_irq), 32'h2);
    chk("R8", "ctx1 idx", idx_of(1), 32'd10);
    bus_write(12'h828, 32'h3); settle(1);
    chk("R8", "invalid context ignored", 32'(ctx_irq), 32'h2);
    bus_read(12'h828, d); chk("R8", "map readback", d, 32'h1);
    bus_write(12'h828, 32'h0);
    irq_in[10] = 1'b0;
    disable_all();
  endtask

  task automatic t_priority();
    bus_write(12'h300, 32'h0010_1000);
    bus_write(12'h304, 32'h0000_0008);
    irq_in[12] = 1'b1; irq_in[20] = 1'b1; irq_in[35] = 1'b1; settle(1);
    chk("R9", "lowest of three", idx_of(0), 32'd12);
    irq_in[12] = 1'b0; settle(1);
    chk("R9", "next lowest", idx_of(0), 32'd20);
    bus_write(12'h88C, 32'h2); settle(1);
    chk("R9", "two contexts active", 32'(ctx_irq), 32'h5);
    chk("R9", "ctx2 idx", idx_of(2), 32'd35);
    irq_in[20] = 1'b0; irq_in[35] = 1'b0; settle(1);
    chk("R9", "all quiet", 32'(ctx_irq), 32'h0);
    disable_all();
  endtask

  task automatic t_read();
    logic [31:0] d;
    bus_read(12'h0FC, d); chk("R10", "unmapped address", d, 32'h0);
    bus_read(12'h108, d); chk("R10", "word past last line", d, 32'h0);
    bus_read(12'h000, d);
    addr = 12'h100; settle(2);
    chk("R10", "data held without strobe", rd_data, 32'h0004_0002);
  endtask

  initial begin
    rst_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0; irq_in = '0;
    #1 rst_n = 1'b0;
    settle(3);
    rst_n = 1'b1;
    settle(3);
    t_reset();
    t_config();
    t_level();
    t_edge();
    t_dual();
    t_mask();
    t_wedge();
    t_route();
    t_priority();
    t_read();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule